// File: doc/BRIEF.md
# Flag-Conditioned Short Branch Resolver

This block resolves a conditional short relative branch. Each request carries a 4-bit condition selector, a 9-bit signed displacement, the program counter of the branch and five status flags: overflow, carry, zero, sign and saturation. The block decides whether the branch is taken. It returns the program counter of the next instruction: the branch target when the branch is taken, and the sequential successor when it is not.

The condition logic and the address arithmetic are combinational. A parameter inserts one register stage at the outputs, so the block can sit on either side of a pipeline boundary. A valid strobe qualifies each request. The taken output never rises for a cycle that carries no request.

Top module: `brcond_unit`

## Requirements
- R1: The 9-bit displacement is sign-extended from its bit 8 to 32 bits. When the branch is taken, the next PC is the current PC plus that value, so 9'h100 moves back by 256 and 9'h0FF moves forward by 255.
- R2: Selectors 0, 1, 2, 3 and 4 take the branch when, respectively: overflow is 1; carry is 1; zero is 1; carry OR zero is 1; sign is 1.
- R3: Selector 5 takes the branch for every combination of the five flags.
- R4: Selector 6 takes the branch when sign XOR overflow is 1. Selector 7 takes it when zero OR (sign XOR overflow) is 1.
- R5: Selectors 8, 9, 10, 11 and 12 take the branch exactly when selectors 0, 1, 2, 3 and 4 respectively would not.
- R6: Selector 13 takes the branch when the saturation flag is 1, whatever the other flags are.
- R7: Selectors 14 and 15 take the branch exactly when selectors 6 and 7 respectively would not.
- R8: When the branch is not taken, the next PC is the current PC plus INSN_LEN (default 2).
- R9: Both the target sum and the sequential sum wrap modulo 2^32.
- R10: The taken output is 1 only for a request whose valid strobe is 1. The output valid follows the input strobe.
- R11: With REG_OUT=1, the results of a request appear one clock after it is presented. While reset is held, out_valid, taken and next_pc are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| condSel | input | 4 | Branch condition selector |
| dispField | input | 9 | Signed displacement field |
| curPc | input | 32 | Program counter of the branch |
| flagOv | input | 1 | Overflow flag |
| flagCy | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagSat | input | 1 | Saturation flag |
| outValid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| nextPc | output | 32 | Next program counter |

## Verification
The bench builds the block with REG_OUT=1 and INSN_LEN=2. The registered stage brings the one-cycle latency and the reset state within reach, and a scoreboard queue checks them. With those values, all sixteen selectors are swept against all 32 flag patterns. The displacement is driven to -256 and +255, and some program counters sit next to the top and the bottom of the address space, so both sums wrap. Idle cycles with selector 5 on the inputs show that the taken output stays low without a strobe.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Status flags presented with each request
  typedef struct packed {
    logic sat;
    logic s;
    logic z;
    logic cy;
    logic ov;
  } brc_flags_t;

  // Strobes from the condition control into the address datapath
  typedef struct packed {
    logic take;
    logic valid;
  } brc_strobe_t;

  // Selector encodings; bit 3 inverts the low-half test, except at 13
  typedef enum logic [3:0] {
    SEL_OV   = 4'd0,
    SEL_CY   = 4'd1,
    SEL_Z    = 4'd2,
    SEL_CYZ  = 4'd3,
    SEL_S    = 4'd4,
    SEL_ALW  = 4'd5,
    SEL_LT   = 4'd6,
    SEL_LE   = 4'd7,
    SEL_NOV  = 4'd8,
    SEL_NCY  = 4'd9,
    SEL_NZ   = 4'd10,
    SEL_NCYZ = 4'd11,
    SEL_NS   = 4'd12,
    SEL_SAT  = 4'd13,
    SEL_GE   = 4'd14,
    SEL_GT   = 4'd15
  } brc_sel_e;

endpackage

// File: rtl/brc_ctrl.sv
module brc_ctrl
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [3:0]  condSel,
  input  brc_flags_t  flags,
  output brc_strobe_t strobes
);

  logic       signedLess;
  logic       baseHit;
  logic       condHit;
  logic [2:0] lowSel;
  logic       invertSel;

  assign signedLess = flags.s ^ flags.ov;
  assign lowSel     = condSel[2:0];
  assign invertSel  = condSel[3];

  // Base test for the lower half of the selector space
  always_comb begin
    unique case (lowSel)
      3'd0: baseHit = flags.ov;
      3'd1: baseHit = flags.cy;
      3'd2: baseHit = flags.z;
      3'd3: baseHit = flags.cy | flags.z;
      3'd4: baseHit = flags.s;
      3'd5: baseHit = 1'b1;
      3'd6: baseHit = signedLess;
      default: baseHit = flags.z | signedLess;
    endcase
  end

  // Upper half negates, except the slot paired with "always"
  always_comb begin
    if (condSel == SEL_SAT) condHit = flags.sat;
    else                    condHit = baseHit ^ invertSel;
  end

  assign strobes.valid = inValid;
  assign strobes.take  = inValid & condHit;

  // R3
  always_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condSel == SEL_ALW) |-> strobes.take);

  // R10
  take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |-> inValid);

  // R6
  sat_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condSel == SEL_SAT) |-> (strobes.take == flags.sat));

endmodule

// File: rtl/brc_datapath.sv
module brc_datapath
  import brc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DISP_W   = 9,
  parameter int INSN_LEN = 2,
  parameter bit REG_OUT  = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  brc_strobe_t       strobes,
  input  logic [DISP_W-1:0] dispField,
  input  logic [PC_W-1:0]   curPc,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc
);

  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] dispExt;
  logic [PC_W-1:0] targetPc;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] nextPcComb;

  assign dispExt    = {{EXT_W{dispField[DISP_W-1]}}, dispField};
  assign targetPc   = curPc + dispExt;
  assign seqPc      = curPc + PC_W'(INSN_LEN);
  assign nextPcComb = strobes.take ? targetPc : seqPc;

  generate
    if (REG_OUT) begin : g_reg
      logic            validQ;
      logic            takenQ;
      logic [PC_W-1:0] pcQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ <= 1'b0;
          takenQ <= 1'b0;
          pcQ    <= '0;
        end else begin
          validQ <= strobes.valid;
          takenQ <= strobes.take;
          pcQ    <= nextPcComb;
        end
      end

      assign outValid = validQ;
      assign taken    = takenQ;
      assign nextPc   = pcQ;

      // R11
      latency_chk: assert property (@(posedge clk) disable iff (!rstN)
        outValid == $past(strobes.valid));

      // R10
      taken_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
        taken |-> outValid);
    end else begin : g_comb
      assign outValid = strobes.valid;
      assign taken    = strobes.take;
      assign nextPc   = nextPcComb;
    end
  endgenerate

  // R1
  zero_disp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.take && dispField == '0) |-> (nextPcComb == curPc));

  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.take) |-> ((nextPcComb - curPc) == PC_W'(INSN_LEN)));

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brc_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int DISP_W   = 9,
  parameter int INSN_LEN = 2,
  parameter bit REG_OUT  = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        condSel,
  input  logic [DISP_W-1:0] dispField,
  input  logic [PC_W-1:0]   curPc,
  input  logic              flagOv,
  input  logic              flagCy,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagSat,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc
);

  brc_flags_t  flagBus;
  brc_strobe_t strobes;

  assign flagBus = '{sat: flagSat, s: flagS, z: flagZ, cy: flagCy, ov: flagOv};

  brc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .condSel (condSel),
    .flags   (flagBus),
    .strobes (strobes)
  );

  brc_datapath #(
    .PC_W     (PC_W),
    .DISP_W   (DISP_W),
    .INSN_LEN (INSN_LEN),
    .REG_OUT  (REG_OUT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dispField (dispField),
    .curPc     (curPc),
    .outValid  (outValid),
    .taken     (taken),
    .nextPc    (nextPc)
  );

endmodule

// File: tb/brcond_unit_tb_top.sv
module brcond_unit_tb_top;

  localparam int LEN = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  condSel = '0;
  logic [8:0]  dispField = '0;
  logic [31:0] curPc = '0;
  logic        flagOv = 0, flagCy = 0, flagZ = 0, flagS = 0, flagSat = 0;
  logic        outValid, taken;
  logic [31:0] nextPc;

  int checks = 0;
  int fails  = 0;
  bit running = 0;
  bit finished = 0;

  typedef struct {
    logic        taken;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #4 clk = ~clk;

  brcond_unit #(.INSN_LEN(LEN), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .condSel(condSel),
    .dispField(dispField), .curPc(curPc), .flagOv(flagOv), .flagCy(flagCy),
    .flagZ(flagZ), .flagS(flagS), .flagSat(flagSat),
    .outValid(outValid), .taken(taken), .nextPc(nextPc)
  );

  // Flag pattern bits: [4]=sat [3]=s [2]=z [1]=cy [0]=ov
  function automatic logic refTake(input logic [3:0] c, input logic [4:0] f);
    logic ov, cy, z, s, sat;
    {sat, s, z, cy, ov} = f;
    case (c)
      4'd0:  return ov;
      4'd1:  return cy;
      4'd2:  return z;
      4'd3:  return cy | z;
      4'd4:  return s;
      4'd5:  return 1'b1;
      4'd6:  return s ^ ov;
      4'd7:  return z | (s ^ ov);
      4'd8:  return !ov;
      4'd9:  return !cy;
      4'd10: return !z;
      4'd11: return !cy && !z;
      4'd12: return !s;
      4'd13: return sat;
      4'd14: return !(s ^ ov);
      default: return !(z | (s ^ ov));
    endcase
  endfunction

  function automatic string condTag(input logic [3:0] c);
    if (c <= 4)       return "R2";
    else if (c == 5)  return "R3";
    else if (c <= 7)  return "R4";
    else if (c <= 12) return "R5";
    else if (c == 13) return "R6";
    else              return "R7";
  endfunction

  task automatic drive(input logic [3:0] c, input logic [8:0] d,
                       input logic [31:0] pc, input logic [4:0] f,
                       input string pcTag);
    exp_t e;
    @(negedge clk);
    inValid   = 1'b1;
    condSel   = c;
    dispField = d;
    curPc     = pc;
    {flagSat, flagS, flagZ, flagCy, flagOv} = f;
    e.taken = refTake(c, f);
    e.pc    = e.taken ? pc + {{23{d[8]}}, d} : pc + 32'(LEN);
    if (pcTag != "") e.tag = pcTag;
    else e.tag = e.taken ? {condTag(c), "/R1"} : {condTag(c), "/R8"};
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      condSel = 4'd5;
      {flagSat, flagS, flagZ, flagCy, flagOv} = 5'b11111;
    end
  endtask

  // Monitor: pops an expected item for each result the design produces
  always @(posedge clk) begin
    #2;
    if (running) begin
      checks++;
      if (outValid) begin
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R11: unexpected result valid=%0b, expected 0", outValid);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (taken !== e.taken || nextPc !== e.pc) begin
            fails++;
            $display("FAIL %s: taken=%0b nextPc=%h, expected taken=%0b nextPc=%h",
                     e.tag, taken, nextPc, e.taken, e.pc);
          end
        end
      end else if (taken !== 1'b0) begin
        // R10: no request, no taken
        fails++;
        $display("FAIL R10: taken=%0b without strobe, expected 0", taken);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    checks++;
    if (outValid !== 1'b0 || taken !== 1'b0 || nextPc !== 32'h0) begin
      fails++;
      $display("FAIL R11: reset valid=%0b taken=%0b pc=%h, expected 0 0 00000000",
               outValid, taken, nextPc);
    end
    rstN = 1'b1;
    running = 1'b1;
    idle(2);

    // R2..R7 with R1/R8: every selector against every flag pattern
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        drive(4'(c), 9'((c * 37 + f * 13) % 512),
              32'h0000_4000 + 32'(c * 256) + 32'(f * 4), 5'(f), "");
      end
      idle(1);
    end

    // R1: displacement extremes
    drive(4'd5, 9'h100, 32'h0000_1000, 5'd0, "R1");
    drive(4'd5, 9'h0FF, 32'h0000_1000, 5'd0, "R1");
    drive(4'd13, 9'h100, 32'h0000_2002, 5'b10000, "R1");
    // R9: wrap of both sums
    drive(4'd5, 9'h004, 32'hFFFF_FFFE, 5'd0, "R9");
    drive(4'd5, 9'h100, 32'h0000_0010, 5'd0, "R9");
    drive(4'd8, 9'h0FF, 32'hFFFF_FFFF, 5'b00001, "R9");
    // R10: strobe low with selector 5 (idle cycles), then back to back
    idle(3);
    drive(4'd5, 9'h002, 32'h0000_0100, 5'd0, "R10");
    idle(1);
    drive(4'd0, 9'h1FE, 32'h0000_0100, 5'd0, "R10");
    idle(4);

    // R11: every pushed result must have come back
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d results missing, expected 0", expQ.size());
    end
    running = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule